// File: doc/BRIEF.md
# Buffered 10-bit PWM Generator

This block produces a pulse-width modulated waveform from an 8-bit period timer. A prescaler divides the input clock by 1, 4 or 16 and counts four phases per timer step. Two bits taken from that prescaler are appended below the timer to form a 10-bit count. The 10-bit duty value is compared against this count. The timer restarts after it reaches the period value, so one PWM period lasts (period + 1) × 4 × prescale input clocks.

The duty value, the polarity and the complementary-mode enable can be written at any time. They are copied into shadow registers only at a period boundary, so a write never shortens or splits a pulse. The dead-band delay has its own shadow, which is reloaded at every duty match and at every period boundary. In complementary mode a four-state machine drives the two outputs: `ST_COMP_ON`, `ST_GAP_TO_MAIN`, `ST_MAIN_ON` and `ST_GAP_TO_COMP`. A change of the raw waveform moves an ON state into the gap state that leads to the other output. A gap state moves on to its ON state once the gap counter reaches the delay. If the raw waveform turns back while a gap is still counting, the machine moves to the opposite gap state. When the delay is zero, an ON state moves directly to the other ON state. A one-clock pulse marks each period boundary.

Top module: `pwm10_gen`

## Requirements
- R1: `period_strobe_o` is high for exactly one clock in every (period_i + 1) × 4 × F clocks, where F is 1 for `presc_sel_i` = 00, 4 for 01, and 16 for 10 or 11. The first strobe comes that many clocks after reset is released.
- R2: After reset both outputs sit at the low (inactive, active-high) level and the shadows hold zero. The first period after reset produces no active pulse.
- R3: In standard mode (enable shadow 0), the primary output is active from each period boundary for duty × F clocks. The upper 8 duty bits compare against the timer and the lower 2 bits compare against the prescaler phase.
- R4: A duty value of 0 keeps the primary output inactive for the whole period.
- R5: A duty value of 4 × (period_i + 1) or more produces no inactive edge, so the primary output stays active for the whole period.
- R6: A new duty, polarity or mode-enable value written mid-period has no effect on the outputs until the next period boundary.
- R7: A polarity shadow of 1 inverts both outputs, so the active level is low.
- R8: In standard mode the complementary output stays at its inactive level.
- R9: In complementary mode the primary output becomes active once the raw waveform has been active for delay + 1 consecutive clocks. The complementary output becomes inactive one clock after the raw waveform turns active. The two outputs are never active together.
- R10: In complementary mode the complementary output becomes active after delay + 1 consecutive clocks of inactive raw waveform. An output whose phase ends before its delay has expired stays inactive for that whole phase.
- R11: The delay shadow takes a new `db_delay_i` value at the first duty match or period boundary after the write, whichever comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_i | input | 8 | Period value compared against the timer |
| duty_i | input | 10 | Duty value, loaded into its shadow at a period boundary |
| presc_sel_i | input | 2 | Prescale select: 00 gives 1, 01 gives 4, 1x gives 16 |
| polarity_i | input | 1 | 1 selects active-low outputs |
| db_en_i | input | 1 | 1 selects complementary dead-band mode |
| db_delay_i | input | 8 | Dead-band delay in input clocks |
| pwm_a_o | output | 1 | Primary PWM output |
| pwm_b_o | output | 1 | Complementary PWM output |
| period_strobe_o | output | 1 | One-clock pulse at each period boundary |

## Verification
The assertions assume that `period_i` and `presc_sel_i` stay constant between resets, because the timer compares them live and does not shadow them. The stimulus changes these two inputs only while reset is held. The buffered inputs (duty, polarity, mode enable, delay) are changed freely, including in the middle of a period. Sweeps cover every duty value from zero to past the period end, for each prescale setting and several period values. Some sweep runs use a delay longer than a raw phase, so the suppression case of R10 is exercised.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
    localparam int TMR_W  = 8;
    localparam int SUB_W  = 2;
    localparam int DUTY_W = TMR_W + SUB_W;
    localparam int FINE_W = 6;

    typedef enum logic [1:0] {
        PS_DIV1  = 2'b00,
        PS_DIV4  = 2'b01,
        PS_DIV16 = 2'b10
    } presc_e;

    typedef enum logic [1:0] {
        ST_COMP_ON,
        ST_GAP_TO_MAIN,
        ST_MAIN_ON,
        ST_GAP_TO_COMP
    } db_state_e;
endpackage

// File: rtl/pwm10_prescaler.sv
module pwm10_prescaler
    import pwm10_pkg::*;
#(
    parameter int FW = FINE_W,
    parameter int SW = SUB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    sel_i,
    output logic [FW-1:0] fine_o,
    output logic          wrap_o,
    output logic [SW-1:0] sub_next_o
);
    localparam logic [FW-1:0] LIM1  = FW'(3);
    localparam logic [FW-1:0] LIM4  = FW'(15);
    localparam logic [FW-1:0] LIM16 = FW'(63);

    logic [FW-1:0] fine_q;
    logic [FW-1:0] fine_next;
    logic [FW-1:0] limit;

    always_comb begin
        unique case (sel_i)
            PS_DIV1: limit = LIM1;
            PS_DIV4: limit = LIM4;
            default: limit = LIM16;
        endcase
    end

    assign wrap_o    = (fine_q == limit);
    assign fine_next = wrap_o ? '0 : fine_q + FW'(1);

    always_comb begin
        unique case (sel_i)
            PS_DIV1: sub_next_o = fine_next[1:0];
            PS_DIV4: sub_next_o = fine_next[3:2];
            default: sub_next_o = fine_next[5:4];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fine_q <= '0;
        else        fine_q <= fine_next;
    end

    assign fine_o = fine_q;
endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
    import pwm10_pkg::*;
#(
    parameter int TW = TMR_W,
    parameter int SW = SUB_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   period_i,
    input  logic            wrap_i,
    input  logic [SW-1:0]   sub_next_i,
    output logic [TW-1:0]   tmr_o,
    output logic            boundary_o,
    output logic [TW+SW-1:0] cnt_next_o
);
    logic [TW-1:0] tmr_q;
    logic [TW-1:0] tmr_next;

    assign boundary_o = wrap_i && (tmr_q == period_i);

    always_comb begin
        if (boundary_o)  tmr_next = '0;
        else if (wrap_i) tmr_next = tmr_q + TW'(1);
        else             tmr_next = tmr_q;
    end

    assign cnt_next_o = {tmr_next, sub_next_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_next;
    end

    assign tmr_o = tmr_q;
endmodule

// File: rtl/pwm10_duty_unit.sv
module pwm10_duty_unit
    import pwm10_pkg::*;
#(
    parameter int DW = DUTY_W,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary_i,
    input  logic [DW-1:0] cnt_next_i,
    input  logic [DW-1:0] duty_i,
    input  logic          pol_i,
    input  logic          db_en_i,
    input  logic [BW-1:0] dly_i,
    output logic [DW-1:0] duty_sh_o,
    output logic          pol_sh_o,
    output logic          db_sh_o,
    output logic [BW-1:0] dly_sh_o,
    output logic          raw_o,
    output logic          strobe_o
);
    logic [DW-1:0] duty_sh;
    logic          pol_sh;
    logic          db_sh;
    logic [BW-1:0] dly_sh;
    logic          raw_q;
    logic          strobe_q;
    logic          match;

    assign match = !boundary_i && (cnt_next_i == duty_sh);

    // control shadows: period boundary only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_sh <= '0;
            pol_sh  <= 1'b0;
            db_sh   <= 1'b0;
        end else if (boundary_i) begin
            duty_sh <= duty_i;
            pol_sh  <= pol_i;
            db_sh   <= db_en_i;
        end
    end

    // delay shadow: earliest of duty match or period boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  dly_sh <= '0;
        else if (boundary_i || match) dly_sh <= dly_i;
    end

    // raw waveform: set at boundary unless zero duty, clear on match
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= boundary_i;
            if (boundary_i)  raw_q <= (duty_i != '0);
            else if (match)  raw_q <= 1'b0;
        end
    end

    assign duty_sh_o = duty_sh;
    assign pol_sh_o  = pol_sh;
    assign db_sh_o   = db_sh;
    assign dly_sh_o  = dly_sh;
    assign raw_o     = raw_q;
    assign strobe_o  = strobe_q;
endmodule

// File: rtl/pwm10_deadband.sv
module pwm10_deadband
    import pwm10_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_i,
    input  logic [BW-1:0] dly_i,
    output logic          main_act_o,
    output logic          comp_act_o
);
    db_state_e     state_q, state_d;
    logic [BW-1:0] gap_q, gap_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COMP_ON;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            ST_COMP_ON: begin
                if (raw_i) begin
                    state_d = (dly_i == '0) ? ST_MAIN_ON : ST_GAP_TO_MAIN;
                    gap_d   = BW'(1);
                end
            end
            ST_GAP_TO_MAIN: begin
                if (!raw_i) begin
                    state_d = (dly_i == '0) ? ST_COMP_ON : ST_GAP_TO_COMP;
                    gap_d   = BW'(1);
                end else if (gap_q >= dly_i) begin
                    state_d = ST_MAIN_ON;
                end else begin
                    gap_d = gap_q + BW'(1);
                end
            end
            ST_MAIN_ON: begin
                if (!raw_i) begin
                    state_d = (dly_i == '0) ? ST_COMP_ON : ST_GAP_TO_COMP;
                    gap_d   = BW'(1);
                end
            end
            ST_GAP_TO_COMP: begin
                if (raw_i) begin
                    state_d = (dly_i == '0) ? ST_MAIN_ON : ST_GAP_TO_MAIN;
                    gap_d   = BW'(1);
                end else if (gap_q >= dly_i) begin
                    state_d = ST_COMP_ON;
                end else begin
                    gap_d = gap_q + BW'(1);
                end
            end
            default: begin
                state_d = ST_COMP_ON;
                gap_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        main_act_o = (state_q == ST_MAIN_ON);
        comp_act_o = (state_q == ST_COMP_ON);
    end
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
    import pwm10_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  period_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [1:0]        presc_sel_i,
    input  logic              polarity_i,
    input  logic              db_en_i,
    input  logic [DB_W-1:0]   db_delay_i,
    output logic              pwm_a_o,
    output logic              pwm_b_o,
    output logic              period_strobe_o
);
    logic [FINE_W-1:0] fine_cnt;
    logic              wrap;
    logic [SUB_W-1:0]  sub_next;
    logic [TMR_W-1:0]  tmr_cnt;
    logic              boundary;
    logic [DUTY_W-1:0] cnt_next;
    logic [DUTY_W-1:0] duty_sh;
    logic              pol_sh;
    logic              db_sh;
    logic [DB_W-1:0]   dly_sh;
    logic              raw_q;
    logic              main_act;
    logic              comp_act;

    pwm10_prescaler #(.FW(FINE_W), .SW(SUB_W)) i_presc (
        .clk(clk), .rst_n(rst_n), .sel_i(presc_sel_i),
        .fine_o(fine_cnt), .wrap_o(wrap), .sub_next_o(sub_next)
    );

    pwm10_timebase #(.TW(TMR_W), .SW(SUB_W)) i_tb (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .wrap_i(wrap),
        .sub_next_i(sub_next), .tmr_o(tmr_cnt), .boundary_o(boundary),
        .cnt_next_o(cnt_next)
    );

    pwm10_duty_unit #(.DW(DUTY_W), .BW(DB_W)) i_duty (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .cnt_next_i(cnt_next),
        .duty_i(duty_i), .pol_i(polarity_i), .db_en_i(db_en_i), .dly_i(db_delay_i),
        .duty_sh_o(duty_sh), .pol_sh_o(pol_sh), .db_sh_o(db_sh), .dly_sh_o(dly_sh),
        .raw_o(raw_q), .strobe_o(period_strobe_o)
    );

    pwm10_deadband #(.BW(DB_W)) i_db (
        .clk(clk), .rst_n(rst_n), .raw_i(raw_q), .dly_i(dly_sh),
        .main_act_o(main_act), .comp_act_o(comp_act)
    );

    always_comb begin
        if (db_sh) begin
            pwm_a_o = main_act ^ pol_sh;
            pwm_b_o = comp_act ^ pol_sh;
        end else begin
            pwm_a_o = raw_q ^ pol_sh;
            pwm_b_o = pol_sh;
        end
    end
endmodule

// File: rtl/pwm10_gen_chk.sv
module pwm10_gen_chk
    import pwm10_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [TMR_W-1:0]  period_i,
    input logic              pwm_a_o,
    input logic              pwm_b_o,
    input logic              period_strobe_o,
    input logic              pol_sh,
    input logic [DUTY_W-1:0] duty_sh,
    input logic              raw_q,
    input logic [TMR_W-1:0]  tmr_cnt,
    input logic [FINE_W-1:0] fine_cnt
);
    AST_STROBE_AT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe_o |-> (tmr_cnt == '0 && fine_cnt == '0)); // R1

    AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_sh == '0) |-> !raw_q); // R4

    AST_OVER_DUTY_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_q) |-> (duty_sh <= {period_i, 2'b11})); // R5

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_strobe_o |-> $stable(duty_sh)); // R6

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !((pwm_a_o ^ pol_sh) && (pwm_b_o ^ pol_sh))); // R9
endmodule

bind pwm10_gen pwm10_gen_chk i_chk (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .pwm_a_o(pwm_a_o),
    .pwm_b_o(pwm_b_o), .period_strobe_o(period_strobe_o), .pol_sh(pol_sh),
    .duty_sh(duty_sh), .raw_q(raw_q), .tmr_cnt(tmr_cnt), .fine_cnt(fine_cnt)
);

// File: tb/test_pwm10_gen.sv
`timescale 1ns/1ps
module test_pwm10_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] period_i = '0;
    logic [9:0] duty_i = '0;
    logic [1:0] presc_sel_i = '0;
    logic       polarity_i = 1'b0;
    logic       db_en_i = 1'b0;
    logic [7:0] db_delay_i = '0;
    logic       pwm_a_o, pwm_b_o, period_strobe_o;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    // reference state
    int k, L, F, m_duty, m_dly, run1, run0, dly_prev;
    bit m_pol, m_db, a_on, b_on, raw_prev, m_raw;
    string tag_a, tag_b;

    always #4 clk = ~clk;

    pwm10_gen i_pwm10_gen (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
        .presc_sel_i(presc_sel_i), .polarity_i(polarity_i), .db_en_i(db_en_i),
        .db_delay_i(db_delay_i), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o),
        .period_strobe_o(period_strobe_o)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s k=%0d actual=%b expected=%b", tag, what, k, act, exp);
        end
    endtask

    task automatic compare_outputs(input string ta, input string tb, input bit g0);
        logic ea, eb;
        if (m_db) begin
            ea = a_on ^ m_pol;
            eb = b_on ^ m_pol;
        end else begin
            ea = m_raw ^ m_pol;
            eb = m_pol;
        end
        chk("R1", "strobe", period_strobe_o, g0 && k > 0);
        chk(ta, "pwm_a", pwm_a_o, ea);
        chk(tb, "pwm_b", pwm_b_o, eb);
    endtask

    task automatic start_run(input int per, input int sel, input int duty,
                             input bit pol, input bit db, input int dly);
        rst_n = 1'b0;
        period_i = 8'(per);
        presc_sel_i = 2'(sel);
        duty_i = 10'(duty);
        polarity_i = pol;
        db_en_i = db;
        db_delay_i = 8'(dly);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        F = (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
        L = 4 * F * (per + 1);
        k = 0; m_duty = 0; m_dly = 0; m_pol = 0; m_db = 0;
        a_on = 0; b_on = 1; run1 = 0; run0 = 1; raw_prev = 0; dly_prev = 0; m_raw = 0;
        compare_outputs("R2", "R2", 1'b0);
    endtask

    task automatic step(input string ta_over, input string tb_over);
        int g, c;
        @(posedge clk);
        @(negedge clk);
        k++;
        g = k % L;
        c = g / F;
        if (raw_prev) begin
            run1++; run0 = 0; b_on = 0;
            if (run1 >= dly_prev + 1) a_on = 1;
        end else begin
            run0++; run1 = 0; a_on = 0;
            if (run0 >= dly_prev + 1) b_on = 1;
        end
        if (g == 0) begin
            m_duty = int'(duty_i);
            m_pol = polarity_i;
            m_db = db_en_i;
        end
        m_raw = (c < m_duty);
        if (g == 0 || c == m_duty) m_dly = int'(db_delay_i);
        if (ta_over != "") begin
            tag_a = ta_over; tag_b = tb_over;
        end else if (k < L) begin
            tag_a = "R2"; tag_b = "R2";
        end else if (m_db) begin
            tag_a = "R9"; tag_b = "R10";
        end else begin
            tag_b = "R8";
            if (m_pol) tag_a = "R7";
            else if (m_duty == 0) tag_a = "R4";
            else if (m_duty >= L / F) tag_a = "R5";
            else tag_a = "R3";
        end
        compare_outputs(tag_a, tag_b, g == 0);
        raw_prev = m_raw;
        dly_prev = m_dly;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        int pers[3] = '{0, 1, 3};
        foreach (pers[pi]) begin
            for (int sel = 0; sel < 3; sel++) begin
                for (int d = 0; d <= 4 * (pers[pi] + 1) + 1; d++) begin
                    int mode = (d + sel) % 4;
                    case (mode)
                        0: start_run(pers[pi], sel, d, 1'b0, 1'b0, 0);
                        1: start_run(pers[pi], sel, d, 1'b1, 1'b0, 0);
                        2: start_run(pers[pi], sel, d, 1'b0, 1'b1, 0);
                        default: start_run(pers[pi], sel, d, 1'b1, 1'b1, 2 + pers[pi]);
                    endcase
                    repeat (3 * L + 2) step("", "");
                end
            end
        end

        // maximum duty with a wide period and the 16 prescale setting on code 11
        start_run(2, 3, 1023, 1'b0, 1'b0, 0);
        repeat (2 * L + 3) step("", "");

        // mid-period writes: buffered duty/polarity/mode (R6) and delay loading (R11)
        start_run(3, 0, 5, 1'b0, 1'b1, 1);
        repeat (37) step("", "");
        duty_i = 10'd11;
        db_delay_i = 8'd4;
        repeat (29) step("R6", "R11");
        polarity_i = 1'b1;
        db_en_i = 1'b0;
        repeat (7) step("R6", "R11");
        db_delay_i = 8'd2;
        db_en_i = 1'b1;
        repeat (60) step("R6", "R11");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule